// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects level-sensitive interrupt requests from peripheral lines and from a handful of software-raised sources. It gives each source a programmable priority and tells the processor, through one registered request line, when the strongest pending source outranks the current priority level. Software claims an interrupt by reading an acknowledge register, which returns the winning vector number. The read also lifts the current level to the priority being served and saves the old level in a last-in-first-out stack. An end-of-interrupt write pops the saved level, so nested handlers unwind in reverse order and the level ends back at idle.

Software can also write the current level directly, for example to raise it to the ceiling of every handler that shares a resource. Requests at or below that ceiling are then held off, while anything above it can still preempt. Software sources take the lowest vector numbers. Peripheral line n is reported as vector NUM_SW + n, which is n + 8 with the default settings.

All configuration goes through a simple single-cycle register bus. Read data is registered and appears one cycle after the read strobe. Register offsets: 0 current level (read/write, bits [3:0]); 1 acknowledge (read); 2 end-of-interrupt (write); 3 software request (write bits [7:0] set, bits [15:8] clear, read returns pending bits [7:0]); 4 status (bit 0 stack underflow, bit 1 stack overflow, write 1 to clear); 32 + v is the priority of vector v (bits [3:0]).

Top module: `prio_intc`

## Requirements
- R1: An acknowledge read of an eligible request returns its vector number: software source i gives i, peripheral line n gives n + 8.
- R2: An acknowledge loads the current level (offset 0) with the winner's priority and pushes the previous level onto the stack.
- R3: irq_out is high one cycle after a cycle in which some pending source has a priority strictly above the current level, and low otherwise; a source with priority 0 is never taken.
- R4: Among pending sources that share the highest priority, the lowest vector number wins.
- R5: An end-of-interrupt write with a non-empty stack restores the most recently pushed level, so nested acknowledges unwind in reverse order and end at level 0.
- R6: A write to offset 0 sets the current level without touching the stack; requests at or below it stay pending without asserting irq_out, and higher ones still do.
- R7: Writing a 1 to bit i of offset 3 marks software source i pending, and writing a 1 to bit i+8 clears it (clear wins). A pending software source stays pending until it is cleared or acknowledged, and an acknowledge clears it.
- R8: The stack holds 16 levels. An end-of-interrupt write on an empty stack leaves the level unchanged and sets status bit 0. An acknowledge on a full stack still loads the level but drops the push and sets status bit 1. Both bits stay set until a 1 is written to them.
- R9: An acknowledge read with no eligible request returns 0xFFFF and changes no state.
- R10: After reset, irq_out is 0, the current level is 0, all priorities are 0, no software source is pending, the stack is empty and status is 0.
- R11: Each source's priority register reads back the value written at offset 32 + vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | NUM_PERIPH | Peripheral request lines, level sensitive |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after a read |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
Several input patterns drive the arbitration. A lone request at priority 0 shows that a zero priority is never taken, and a single request above idle shows the strictly-greater comparison. Two peripheral lines raised at the same priority show the tie rule, and a software source against peripheral lines shows the vector offset. A ceiling written while lower requests wait separates gating by the current level from plain masking. The stack is pushed past its depth and popped past empty, which shows both error flags and that unwinding returns to 0. A reference model follows every cycle, so any mismatch in irq_out or read data is caught in the cycle where it first appears.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int REG_CURPRI = 0;
  localparam int REG_ACK    = 1;
  localparam int REG_EOI    = 2;
  localparam int REG_SWREQ  = 3;
  localparam int REG_STATUS = 4;
endpackage

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int NUM_SRC = 24,
  parameter int PRIO_W  = 4,
  localparam int VEC_W  = $clog2(NUM_SRC)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_SRC-1:0]             pend,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
  output logic [VEC_W-1:0]               win_idx,
  output logic [PRIO_W-1:0]              win_pri,
  output logic                           win_valid
);
  // Strictly-greater update keeps the lowest index on ties; priority 0 never wins.
  always_comb begin
    win_pri = '0;
    win_idx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend[i] && (prio[i] > win_pri)) begin
        win_pri = prio[i];
        win_idx = VEC_W'(i);
      end
    end
  end

  assign win_valid = (win_pri != '0);

  // R4 / R3: the reported winner is a pending source carrying the reported priority
  a_r4_winner_pending: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> (pend[win_idx] && (prio[win_idx] == win_pri)));
endmodule

// File: rtl/intc_prio_stack.sv
module intc_prio_stack #(
  parameter int W     = 4,
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int SP_W  = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_data,
  output logic [W-1:0] top_data,
  output logic         empty,
  output logic         full
);
  logic [W-1:0]     mem [DEPTH];
  logic [SP_W-1:0]  sp;
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] top_idx;

  assign wr_idx  = IDX_W'(sp);
  assign top_idx = IDX_W'(sp - 1'b1);
  assign empty   = (sp == '0);
  assign full    = (sp == SP_W'(DEPTH));

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_idx] <= push_data;
  end

  assign top_data = mem[top_idx];

  always_ff @(posedge clk) begin
    if (rst)                sp <= '0;
    else if (push && !full) sp <= sp + 1'b1;
    else if (pop && !empty) sp <= sp - 1'b1;
  end

  a_r8_sp_bound: assert property (@(posedge clk) disable iff (rst)
    sp <= SP_W'(DEPTH));
  a_r5_pop_depth: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && !empty) |=> (sp == $past(sp) - 1'b1));
endmodule

// File: rtl/intc_sw_req.sv
module intc_sw_req #(
  parameter int NUM_SW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_SW-1:0] set_mask,
  input  logic [NUM_SW-1:0] clr_mask,
  input  logic [NUM_SW-1:0] ack_clr,
  output logic [NUM_SW-1:0] pend
);
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend | set_mask) & ~clr_mask & ~ack_clr;
  end

  // R7: an explicit clear always leaves the bit cleared
  a_r7_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (|clr_mask) |=> ((pend & $past(clr_mask)) == '0));
  // R7: a pending bit only drops through clear or acknowledge
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    ((pend[0]) && !clr_mask[0] && !ack_clr[0]) |=> pend[0]);
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int NUM_PERIPH  = 16,
  parameter int NUM_SW      = 8,
  parameter int PRIO_W      = 4,
  parameter int STACK_DEPTH = 16,
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int PRIO_BASE   = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_PERIPH-1:0] irq_src,
  input  logic                  bus_en,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic                  irq_out
);
  localparam int NUM_SRC = NUM_SW + NUM_PERIPH;
  localparam int VEC_W   = $clog2(NUM_SRC);

  logic                           rd, wr;
  logic                           ack_rd, ack_take, eoi_wr, cur_wr, sw_wr, st_wr;
  logic                           eligible;
  logic [PRIO_W-1:0]              cur_pri;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
  logic [NUM_SW-1:0]              sw_pend, sw_set, sw_clr, sw_ack;
  logic [NUM_SRC-1:0]             pend_all;
  logic [VEC_W-1:0]               win_idx;
  logic [PRIO_W-1:0]              win_pri;
  logic                           win_valid;
  logic [PRIO_W-1:0]              stack_top;
  logic                           stk_empty, stk_full, push, pop;
  logic                           und_q, ovf_q;
  logic [DATA_W-1:0]              rd_mux;

  // ---- bus decode ----
  assign rd       = bus_en && !bus_we;
  assign wr       = bus_en && bus_we;
  assign ack_rd   = rd && (bus_addr == ADDR_W'(REG_ACK));
  assign eoi_wr   = wr && (bus_addr == ADDR_W'(REG_EOI));
  assign cur_wr   = wr && (bus_addr == ADDR_W'(REG_CURPRI));
  assign sw_wr    = wr && (bus_addr == ADDR_W'(REG_SWREQ));
  assign st_wr    = wr && (bus_addr == ADDR_W'(REG_STATUS));

  // ---- priority registers ----
  always_ff @(posedge clk) begin
    if (rst) begin
      prio_q <= '0;
    end else if (wr) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (bus_addr == ADDR_W'(PRIO_BASE + i)) prio_q[i] <= bus_wdata[PRIO_W-1:0];
      end
    end
  end

  // ---- software request sources ----
  assign sw_set = sw_wr ? bus_wdata[NUM_SW-1:0] : '0;
  assign sw_clr = sw_wr ? bus_wdata[2*NUM_SW-1:NUM_SW] : '0;

  generate
    for (genvar g = 0; g < NUM_SW; g++) begin : g_swack
      assign sw_ack[g] = ack_take && (win_idx == VEC_W'(g));
    end
  endgenerate

  intc_sw_req #(.NUM_SW(NUM_SW)) i_sw (
    .clk(clk), .rst(rst), .set_mask(sw_set), .clr_mask(sw_clr),
    .ack_clr(sw_ack), .pend(sw_pend)
  );

  // software sources occupy the lowest vectors
  assign pend_all = {irq_src, sw_pend};

  // ---- arbitration ----
  intc_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) i_arb (
    .clk(clk), .rst(rst), .pend(pend_all), .prio(prio_q),
    .win_idx(win_idx), .win_pri(win_pri), .win_valid(win_valid)
  );

  assign eligible = win_valid && (win_pri > cur_pri);
  assign ack_take = ack_rd && eligible;

  // ---- priority stack ----
  assign push = ack_take;
  assign pop  = eoi_wr && !stk_empty;

  intc_prio_stack #(.W(PRIO_W), .DEPTH(STACK_DEPTH)) i_stack (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .push_data(cur_pri),
    .top_data(stack_top), .empty(stk_empty), .full(stk_full)
  );

  // ---- current level ----
  always_ff @(posedge clk) begin
    if (rst)           cur_pri <= '0;
    else if (ack_take) cur_pri <= win_pri;
    else if (pop)      cur_pri <= stack_top;
    else if (cur_wr)   cur_pri <= bus_wdata[PRIO_W-1:0];
  end

  // ---- sticky status ----
  always_ff @(posedge clk) begin
    if (rst) begin
      und_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (eoi_wr && stk_empty)         und_q <= 1'b1;
      else if (st_wr && bus_wdata[0])  und_q <= 1'b0;
      if (ack_take && stk_full)        ovf_q <= 1'b1;
      else if (st_wr && bus_wdata[1])  ovf_q <= 1'b0;
    end
  end

  // ---- read path ----
  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(REG_CURPRI))      rd_mux = DATA_W'(cur_pri);
    else if (bus_addr == ADDR_W'(REG_ACK))    rd_mux = eligible ? DATA_W'(win_idx) : '1;
    else if (bus_addr == ADDR_W'(REG_SWREQ))  rd_mux = DATA_W'(sw_pend);
    else if (bus_addr == ADDR_W'(REG_STATUS)) rd_mux = DATA_W'({ovf_q, und_q});
    else begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (bus_addr == ADDR_W'(PRIO_BASE + i)) rd_mux = DATA_W'(prio_q[i]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      if (rd) bus_rdata <= rd_mux;
      irq_out <= eligible;
    end
  end

  // ---- assertions ----
  a_r2_ack_loads: assert property (@(posedge clk) disable iff (rst)
    ack_take |=> (cur_pri == $past(win_pri)));
  a_r5_eoi_restores: assert property (@(posedge clk) disable iff (rst)
    pop |=> (cur_pri == $past(stack_top)));
  a_r3_irq_needs_request: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(win_valid));
  a_r8_under_sticky: assert property (@(posedge clk) disable iff (rst)
    (und_q && !(st_wr && bus_wdata[0])) |=> und_q);
  a_r9_spurious_quiet: assert property (@(posedge clk) disable iff (rst)
    (ack_rd && !eligible) |=> ($stable(cur_pri) && (bus_rdata == '1)));
endmodule

// File: tb/test_prio_intc.sv
`timescale 1ns/1ps
module test_prio_intc;
  localparam int NP = 16, NSW = 8, NSRC = NP + NSW, DEPTH = 16, PB = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [NP-1:0] irq_src = '0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq_out;

  int checks = 0, errors = 0;
  string phase = "R10";

  always #2.5 clk = ~clk;

  prio_intc i_prio_intc (
    .clk(clk), .rst(rst), .irq_src(irq_src), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  // ---------------- reference model ----------------
  int m_prio [NSRC];
  bit m_sw [NSW];
  int m_cur;
  int m_stk [$];
  bit m_und, m_ovf;
  bit exp_irq;
  bit rd_chk;
  logic [15:0] exp_rd;

  function automatic void find_best(output int bp, output int bi);
    bp = 0; bi = 0;
    for (int i = 0; i < NSRC; i++) begin
      bit p;
      p = (i < NSW) ? m_sw[i] : irq_src[i-NSW];
      if (p && m_prio[i] > bp) begin bp = m_prio[i]; bi = i; end
    end
  endfunction

  function automatic int sw_bits();
    int v = 0;
    for (int i = 0; i < NSW; i++) if (m_sw[i]) v |= (1 << i);
    return v;
  endfunction

  always @(posedge clk) begin
    int bp, bi, a, d;
    bit elig;
    if (rst) begin
      for (int i = 0; i < NSRC; i++) m_prio[i] = 0;
      for (int i = 0; i < NSW; i++) m_sw[i] = 0;
      m_cur = 0; m_stk.delete(); m_und = 0; m_ovf = 0;
      exp_irq = 0; rd_chk = 0; exp_rd = '0;
    end else begin
      find_best(bp, bi);
      elig = (bp > m_cur);
      a = int'(bus_addr); d = int'(bus_wdata);
      rd_chk = 0;
      if (bus_en && !bus_we) begin
        rd_chk = 1;
        exp_rd = '0;
        if (a == 0) exp_rd = 16'(m_cur);
        else if (a == 1) begin
          if (elig) begin
            exp_rd = 16'(bi);
            if (m_stk.size() < DEPTH) m_stk.push_back(m_cur); else m_ovf = 1;
            m_cur = bp;
            if (bi < NSW) m_sw[bi] = 0;
          end else exp_rd = 16'hFFFF;
        end
        else if (a == 3) exp_rd = 16'(sw_bits());
        else if (a == 4) exp_rd = 16'({m_ovf, m_und});
        else if (a >= PB && a < PB + NSRC) exp_rd = 16'(m_prio[a-PB]);
      end else if (bus_en && bus_we) begin
        if (a == 0) m_cur = d & 15;
        else if (a == 2) begin
          if (m_stk.size() > 0) m_cur = m_stk.pop_back(); else m_und = 1;
        end
        else if (a == 3) begin
          for (int i = 0; i < NSW; i++) begin
            if (d[i]) m_sw[i] = 1;
            if (d[i+NSW]) m_sw[i] = 0;
          end
        end
        else if (a == 4) begin
          if (d[0]) m_und = 0;
          if (d[1]) m_ovf = 0;
        end
        else if (a >= PB && a < PB + NSRC) m_prio[a-PB] = d & 15;
      end
      exp_irq = elig;
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (irq_out !== exp_irq) begin
        errors++;
        $display("FAIL %s (R3 per-cycle irq_out) actual=%0b expected=%0b at %0t", phase, irq_out, exp_irq, $time);
      end
      if (rd_chk) begin
        checks++;
        if (bus_rdata !== exp_rd) begin
          errors++;
          $display("FAIL %s (read data model) actual=%h expected=%h at %0t", phase, bus_rdata, exp_rd, $time);
        end
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic bwr(input int addr, input int data);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = 6'(addr); bus_wdata = 16'(data);
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic brd(input int addr, output int data);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = 6'(addr);
    @(negedge clk);
    bus_en = 1'b0;
    data = int'(bus_rdata);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    int v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    phase = "R10";
    chk("R10 irq_out after reset", int'(irq_out), 0);
    brd(0, v);  chk("R10 level after reset", v, 0);
    brd(4, v);  chk("R10 status after reset", v, 0);
    brd(3, v);  chk("R10 sw pending after reset", v, 0);
    brd(PB + 9, v); chk("R10 priority after reset", v, 0);

    phase = "R11";
    bwr(PB + 8, 1); bwr(PB + 9, 3); bwr(PB + 10, 3);
    bwr(PB + 0, 2); bwr(PB + 1, 3);
    brd(PB + 9, v); chk("R11 readback vec9", v, 3);
    brd(PB + 0, v); chk("R11 readback vec0", v, 2);

    phase = "R3";
    irq_src[5] = 1'b1; settle();
    chk("R3 priority 0 never asserts", int'(irq_out), 0);
    irq_src[0] = 1'b1; settle();
    chk("R3 pri1 above idle asserts", int'(irq_out), 1);
    phase = "R1";
    brd(1, v); chk("R1 peripheral 0 gives vector 8", v, 8);
    brd(0, v); chk("R2 level loaded with 1", v, 1);
    settle();
    chk("R3 equal to level does not assert", int'(irq_out), 0);

    phase = "R4";
    irq_src[1] = 1'b1; irq_src[2] = 1'b1; settle();
    chk("R4 irq with tie", int'(irq_out), 1);
    brd(1, v); chk("R4 tie goes to lowest vector", v, 9);
    brd(0, v); chk("R2 nested level 3", v, 3);
    irq_src[1] = 1'b0; irq_src[2] = 1'b0;

    phase = "R5";
    bwr(2, 0); brd(0, v); chk("R5 first unwind 3->1", v, 1);
    irq_src[0] = 1'b0;
    bwr(2, 0); brd(0, v); chk("R5 second unwind 1->0", v, 0);
    settle(); chk("R5 idle no irq", int'(irq_out), 0);

    phase = "R6";
    bwr(0, 3);
    bwr(3, 16'h0001);
    settle(); chk("R6 sw0 pri2 blocked by ceiling", int'(irq_out), 0);
    brd(3, v); chk("R7 sw0 pending", v, 1);
    irq_src[1] = 1'b1; settle();
    chk("R6 pri3 at ceiling blocked", int'(irq_out), 0);
    bwr(PB + 11, 5); irq_src[3] = 1'b1; settle();
    chk("R6 pri5 above ceiling preempts", int'(irq_out), 1);
    brd(1, v); chk("R1 peripheral 3 gives vector 11", v, 11);
    bwr(2, 0); brd(0, v); chk("R6 ceiling restored after EOI", v, 3);
    bwr(0, 0); irq_src[1] = 1'b0; irq_src[3] = 1'b0; settle();
    chk("R6 lowered level releases sw0", int'(irq_out), 1);
    phase = "R7";
    brd(1, v); chk("R1 software source 0 gives vector 0", v, 0);
    brd(3, v); chk("R7 acknowledge clears sw pending", v, 0);
    bwr(2, 0); brd(0, v); chk("R5 back to 0", v, 0);

    bwr(3, 16'h0002); brd(3, v); chk("R7 set sw1", v, 2);
    bwr(3, 16'h0200); brd(3, v); chk("R7 clear sw1", v, 0);
    settle(); chk("R7 cleared source no irq", int'(irq_out), 0);

    phase = "R9";
    brd(1, v); chk("R9 spurious vector", v, 16'hFFFF);
    brd(0, v); chk("R9 level unchanged", v, 0);

    phase = "R8";
    bwr(2, 0); brd(4, v); chk("R8 underflow flag", v, 1);
    brd(0, v); chk("R8 level unchanged on underflow", v, 0);
    bwr(4, 1); brd(4, v); chk("R8 underflow cleared", v, 0);
    for (int k = 0; k < DEPTH + 1; k++) begin
      bwr(0, 0); bwr(3, 16'h0001);
      brd(1, v); chk("R8 ack during fill", v, 0);
      brd(4, v); chk("R8 overflow flag during fill", v, (k == DEPTH) ? 2 : 0);
    end
    for (int k = 0; k < DEPTH; k++) begin
      bwr(2, 0); brd(0, v); chk("R5 unwind full stack", v, 0);
    end
    brd(4, v); chk("R8 overflow sticky", v, 2);
    bwr(2, 0); brd(4, v); chk("R8 both flags", v, 3);

    settle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule